// File: doc/BRIEF.md
# Exception Entry and Vector Unit

This unit turns an exception request into a pipeline redirect. It also commits the state changes that exception entry requires. A request names the exception kind and carries the program counter of the faulting instruction and a flag that marks that instruction as sitting in a branch delay slot. The surrounding core also supplies its current status bits: exception level, bootstrap-vector select, interrupt-vector select and a refill-miss qualifier. It supplies the programmable exception base as well. From these the unit picks one of three entry paths: general, error (non-maskable interrupt and soft reset) or debug. It computes the target address and the return address, and records the cause information.

All updates commit on the clock edge that samples the request. On that same edge a one-cycle valid pulse presents the new PC. The saved return addresses and cause fields are held in this unit and are exported as outputs. The status bits are owned by the core. For those, the unit emits one-cycle set pulses (exception level, error level, bootstrap, debug mode, kernel mode), and the core merges them into its own status register.

Top module: `trap_vector_ctl`

## Requirements
- R1: While reset is high, and on the first cycle after it, every output is zero.
- R2: A request with a legal kind (code 0 to 25) gives redir_valid_o high, kernel_o high and the target on redir_pc_o for exactly the cycle after the sampling edge. A kind code of 26 to 31 is ignored: no pulse is raised and no saved register changes.
- R3: Kind codes 0 to 17 are general exceptions and write exc_code_o. The kind code and the value written are, in order: interrupt 0→0, TLB modify 1→1, TLB load 2→2, TLB store 3→3, load address error 4→4, store address error 5→5, instruction bus error 6→6, data bus error 7→7, syscall 8→8, break 9→9, reserved instruction 10→10, coprocessor unusable 11→11, overflow 12→12, trap 13→13, floating point 14→15, watch 15→23, machine check 16→24, cache error 17→30.
- R4: The general base is 0xBFC00200 when bev_i is 1 and ebase_i with bits [9:0] cleared when bev_i is 0. The default offset is 0x180.
- R5: An interrupt uses offset 0x200 when iv_i is 1.
- R6: A TLB load or TLB store with refill_i high and exl_i low uses offset 0x000. With exl_i high, or for a non-refill fault, the offset is 0x180. The refill qualifier has no effect on other kinds.
- R7: A cache error uses offset 0x100 when bev_i is 1 and 0x20000100 when bev_i is 0.
- R8: For a general exception with exl_i low, the unit writes epc_o, bd_o and set_exl_o. epc_o is written with pc_i−4 and bd_o set to 1 when delay_slot_i is 1; otherwise epc_o is written with pc_i and bd_o set to 0. set_exl_o pulses. With exl_i high, epc_o and bd_o hold and set_exl_o stays low.
- R9: A coprocessor-unusable exception (kind 11) writes cop_num_i into cop_num_o. Other kinds leave cop_num_o unchanged.
- R10: Non-maskable interrupt (kind 18) and soft reset (kind 19) write err_pc_o under the same delay-slot rule and pulse set_erl_o and set_bev_o. The target is 0xBFC00000. epc_o and exc_code_o are unchanged.
- R11: Debug kinds write dbg_pc_o, pulse set_dm_o and target 0xBFC00480. The debug kinds are single step (20), debug interrupt (21), instruction breakpoint (22), software breakpoint (23), data break store (24) and data break load (25). dbg_pc_o gets pc_i−4 for a delay-slot fault, except for single step, which always saves pc_i.
- R12: Each debug kind sets one sticky bit of dbg_cause_o: bit 0 single step, bit 1 debug interrupt, bit 2 instruction breakpoint, bit 3 software breakpoint, bit 4 data break store, bit 5 data break load. Only reset clears these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Exception request, sampled each edge |
| kind_i | input | 5 | Exception kind code |
| pc_i | input | 32 | PC of the faulting instruction |
| delay_slot_i | input | 1 | Faulting instruction is in a branch delay slot |
| exl_i | input | 1 | Current exception-level bit |
| bev_i | input | 1 | Current bootstrap-vector bit |
| iv_i | input | 1 | Interrupt-vector select bit |
| refill_i | input | 1 | TLB fault was a refill miss |
| cop_num_i | input | 2 | Coprocessor number for coprocessor-unusable |
| ebase_i | input | 32 | Programmable exception base |
| redir_valid_o | output | 1 | One-cycle redirect valid |
| redir_pc_o | output | 32 | New program counter |
| kernel_o | output | 1 | Force-kernel-mode pulse |
| set_exl_o | output | 1 | Set exception level pulse |
| set_erl_o | output | 1 | Set error level pulse |
| set_bev_o | output | 1 | Set bootstrap bit pulse |
| set_dm_o | output | 1 | Enter debug mode pulse |
| epc_o | output | 32 | Saved exception return PC |
| err_pc_o | output | 32 | Saved error return PC |
| dbg_pc_o | output | 32 | Saved debug return PC |
| exc_code_o | output | 5 | Cause exception code |
| bd_o | output | 1 | Cause branch-delay bit |
| cop_num_o | output | 2 | Cause coprocessor-number field |
| dbg_cause_o | output | 6 | Sticky debug cause bits |

## Verification
Two functions meet in one request: choosing the vector offset, and saving the return PC. Both hinge on the exception-level bit, so a TLB refill raised while exl_i is high must fall to offset 0x180 and must also leave epc_o and bd_o untouched. Both outcomes are checked on the same pulse. A second collision comes from two requests on consecutive edges: the first redirect is still presented while the second request is sampled. The bench checks that each cycle shows its own target and that the later save wins.

// File: rtl/trap_vec_pkg.sv
package trap_vec_pkg;

  typedef enum logic [4:0] {
    K_INT    = 5'd0,  K_TLBMOD = 5'd1,  K_TLBLD  = 5'd2,  K_TLBST  = 5'd3,
    K_ADRLD  = 5'd4,  K_ADRST  = 5'd5,  K_IBUS   = 5'd6,  K_DBUS   = 5'd7,
    K_SYS    = 5'd8,  K_BRK    = 5'd9,  K_RSVD   = 5'd10, K_COPU   = 5'd11,
    K_OVF    = 5'd12, K_TRAP   = 5'd13, K_FPE    = 5'd14, K_WATCH  = 5'd15,
    K_MCHK   = 5'd16, K_CACHE  = 5'd17, K_NMI    = 5'd18, K_SRST   = 5'd19,
    K_DSTEP  = 5'd20, K_DINT   = 5'd21, K_DIBRK  = 5'd22, K_DSWBP  = 5'd23,
    K_DDST   = 5'd24, K_DDLD   = 5'd25
  } trap_kind_e;

  typedef enum logic [1:0] {
    P_NONE    = 2'd0,
    P_GENERAL = 2'd1,
    P_ERROR   = 2'd2,
    P_DEBUG   = 2'd3
  } trap_path_e;

  localparam int KIND_W = 5;
  localparam int CODE_W = 5;
  localparam int DBG_W  = 6;

endpackage

// File: rtl/trap_vec_classify.sv
module trap_vec_classify
  import trap_vec_pkg::*;
(
  input  logic [KIND_W-1:0] kind_i,
  output trap_path_e        path_o,
  output logic [CODE_W-1:0] code_o,
  output logic              is_int_o,
  output logic              is_tlb_ls_o,
  output logic              is_cache_o,
  output logic              is_copu_o,
  output logic              is_step_o,
  output logic [DBG_W-1:0]  dbg_hot_o
);

  trap_kind_e k;
  assign k = trap_kind_e'(kind_i);

  always_comb begin
    path_o    = P_GENERAL;
    code_o    = '0;
    dbg_hot_o = '0;
    case (k)
      K_INT:    code_o = 5'd0;
      K_TLBMOD: code_o = 5'd1;
      K_TLBLD:  code_o = 5'd2;
      K_TLBST:  code_o = 5'd3;
      K_ADRLD:  code_o = 5'd4;
      K_ADRST:  code_o = 5'd5;
      K_IBUS:   code_o = 5'd6;
      K_DBUS:   code_o = 5'd7;
      K_SYS:    code_o = 5'd8;
      K_BRK:    code_o = 5'd9;
      K_RSVD:   code_o = 5'd10;
      K_COPU:   code_o = 5'd11;
      K_OVF:    code_o = 5'd12;
      K_TRAP:   code_o = 5'd13;
      K_FPE:    code_o = 5'd15;
      K_WATCH:  code_o = 5'd23;
      K_MCHK:   code_o = 5'd24;
      K_CACHE:  code_o = 5'd30;
      K_NMI, K_SRST: path_o = P_ERROR;
      K_DSTEP:  begin path_o = P_DEBUG; dbg_hot_o = 6'b000001; end
      K_DINT:   begin path_o = P_DEBUG; dbg_hot_o = 6'b000010; end
      K_DIBRK:  begin path_o = P_DEBUG; dbg_hot_o = 6'b000100; end
      K_DSWBP:  begin path_o = P_DEBUG; dbg_hot_o = 6'b001000; end
      K_DDST:   begin path_o = P_DEBUG; dbg_hot_o = 6'b010000; end
      K_DDLD:   begin path_o = P_DEBUG; dbg_hot_o = 6'b100000; end
      default:  path_o = P_NONE;
    endcase
  end

  assign is_int_o    = (k == K_INT);
  assign is_tlb_ls_o = (k == K_TLBLD) || (k == K_TLBST);
  assign is_cache_o  = (k == K_CACHE);
  assign is_copu_o   = (k == K_COPU);
  assign is_step_o   = (k == K_DSTEP);

endmodule

// File: rtl/trap_vec_target.sv
module trap_vec_target
  import trap_vec_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              BASE_LSB    = 10,
  parameter logic [XLEN-1:0] BOOT_BASE   = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] ERR_VEC     = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] DBG_VEC     = 32'hBFC0_0480,
  parameter logic [XLEN-1:0] OFS_GEN     = 32'h0000_0180,
  parameter logic [XLEN-1:0] OFS_INT     = 32'h0000_0200,
  parameter logic [XLEN-1:0] OFS_REFILL  = 32'h0000_0000,
  parameter logic [XLEN-1:0] OFS_CE_BOOT = 32'h0000_0100,
  parameter logic [XLEN-1:0] OFS_CE_RUN  = 32'h2000_0100
) (
  input  trap_path_e      path_i,
  input  logic            is_int_i,
  input  logic            is_tlb_ls_i,
  input  logic            is_cache_i,
  input  logic            refill_i,
  input  logic            exl_i,
  input  logic            bev_i,
  input  logic            iv_i,
  input  logic [XLEN-1:0] ebase_i,
  output logic [XLEN-1:0] target_o
);

  localparam logic [XLEN-1:0] LOW_MASK = (XLEN'(1) << BASE_LSB) - XLEN'(1);

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  assign base = bev_i ? BOOT_BASE : (ebase_i & ~LOW_MASK);

  always_comb begin
    offset = OFS_GEN;
    if (is_int_i && iv_i)
      offset = OFS_INT;
    else if (is_tlb_ls_i && refill_i && !exl_i)
      offset = OFS_REFILL;
    else if (is_cache_i)
      offset = bev_i ? OFS_CE_BOOT : OFS_CE_RUN;
  end

  always_comb begin
    case (path_i)
      P_ERROR: target_o = ERR_VEC;
      P_DEBUG: target_o = DBG_VEC;
      default: target_o = base + offset;
    endcase
  end

endmodule

// File: rtl/trap_vec_retpc.sv
module trap_vec_retpc #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic            delay_slot_i,
  input  logic            keep_cur_i,
  output logic [XLEN-1:0] ret_pc_o
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  assign ret_pc_o = (delay_slot_i && !keep_cur_i) ? (pc_i - STEP) : pc_i;

endmodule

// File: rtl/trap_vector_ctl.sv
module trap_vector_ctl
  import trap_vec_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              CPN_W      = 2,
  parameter int              BASE_LSB   = 10,
  parameter int              INSN_BYTES = 4,
  parameter logic [XLEN-1:0] BOOT_BASE  = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] ERR_VEC    = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] DBG_VEC    = 32'hBFC0_0480
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              delay_slot_i,
  input  logic              exl_i,
  input  logic              bev_i,
  input  logic              iv_i,
  input  logic              refill_i,
  input  logic [CPN_W-1:0]  cop_num_i,
  input  logic [XLEN-1:0]   ebase_i,
  output logic              redir_valid_o,
  output logic [XLEN-1:0]   redir_pc_o,
  output logic              kernel_o,
  output logic              set_exl_o,
  output logic              set_erl_o,
  output logic              set_bev_o,
  output logic              set_dm_o,
  output logic [XLEN-1:0]   epc_o,
  output logic [XLEN-1:0]   err_pc_o,
  output logic [XLEN-1:0]   dbg_pc_o,
  output logic [CODE_W-1:0] exc_code_o,
  output logic              bd_o,
  output logic [CPN_W-1:0]  cop_num_o,
  output logic [DBG_W-1:0]  dbg_cause_o
);

  trap_path_e        path;
  logic [CODE_W-1:0] code;
  logic              is_int, is_tlb_ls, is_cache, is_copu, is_step;
  logic [DBG_W-1:0]  dbg_hot;
  logic [XLEN-1:0]   target;
  logic [XLEN-1:0]   ret_pc;
  logic              take;

  trap_vec_classify u_cls (
    .kind_i      (kind_i),
    .path_o      (path),
    .code_o      (code),
    .is_int_o    (is_int),
    .is_tlb_ls_o (is_tlb_ls),
    .is_cache_o  (is_cache),
    .is_copu_o   (is_copu),
    .is_step_o   (is_step),
    .dbg_hot_o   (dbg_hot)
  );

  trap_vec_target #(
    .XLEN      (XLEN),
    .BASE_LSB  (BASE_LSB),
    .BOOT_BASE (BOOT_BASE),
    .ERR_VEC   (ERR_VEC),
    .DBG_VEC   (DBG_VEC)
  ) u_tgt (
    .path_i      (path),
    .is_int_i    (is_int),
    .is_tlb_ls_i (is_tlb_ls),
    .is_cache_i  (is_cache),
    .refill_i    (refill_i),
    .exl_i       (exl_i),
    .bev_i       (bev_i),
    .iv_i        (iv_i),
    .ebase_i     (ebase_i),
    .target_o    (target)
  );

  trap_vec_retpc #(
    .XLEN       (XLEN),
    .INSN_BYTES (INSN_BYTES)
  ) u_ret (
    .pc_i         (pc_i),
    .delay_slot_i (delay_slot_i),
    .keep_cur_i   (is_step),
    .ret_pc_o     (ret_pc)
  );

  assign take = req_i && (path != P_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid_o <= 1'b0;
      redir_pc_o    <= '0;
      kernel_o      <= 1'b0;
      set_exl_o     <= 1'b0;
      set_erl_o     <= 1'b0;
      set_bev_o     <= 1'b0;
      set_dm_o      <= 1'b0;
      epc_o         <= '0;
      err_pc_o      <= '0;
      dbg_pc_o      <= '0;
      exc_code_o    <= '0;
      bd_o          <= 1'b0;
      cop_num_o     <= '0;
    end else begin
      redir_valid_o <= take;
      kernel_o      <= take;
      set_exl_o     <= 1'b0;
      set_erl_o     <= 1'b0;
      set_bev_o     <= 1'b0;
      set_dm_o      <= 1'b0;
      if (take) begin
        redir_pc_o <= target;
        case (path)
          P_GENERAL: begin
            exc_code_o <= code;
            if (is_copu) cop_num_o <= cop_num_i;
            if (!exl_i) begin
              epc_o     <= ret_pc;
              bd_o      <= delay_slot_i;
              set_exl_o <= 1'b1;
            end
          end
          P_ERROR: begin
            err_pc_o  <= ret_pc;
            set_erl_o <= 1'b1;
            set_bev_o <= 1'b1;
          end
          P_DEBUG: begin
            dbg_pc_o <= ret_pc;
            set_dm_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // sticky debug cause bits, one flop per cause
  for (genvar g = 0; g < DBG_W; g++) begin : g_dbg
    always_ff @(posedge clk) begin
      if (rst)
        dbg_cause_o[g] <= 1'b0;
      else if (take && (path == P_DEBUG) && dbg_hot[g])
        dbg_cause_o[g] <= 1'b1;
    end
  end

endmodule

// File: rtl/trap_vector_chk.sv
module trap_vector_chk #(
  parameter int              XLEN     = 32,
  parameter int              BASE_LSB = 10,
  parameter logic [XLEN-1:0] ERR_VEC  = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] DBG_VEC  = 32'hBFC0_0480
) (
  input logic            clk,
  input logic            rst,
  input logic            req_i,
  input logic [4:0]      kind_i,
  input logic            exl_i,
  input logic            bev_i,
  input logic            refill_i,
  input logic [XLEN-1:0] ebase_i,
  input logic            redir_valid_o,
  input logic [XLEN-1:0] redir_pc_o,
  input logic            kernel_o,
  input logic            set_exl_o,
  input logic            set_erl_o,
  input logic            set_bev_o,
  input logic            set_dm_o,
  input logic [XLEN-1:0] epc_o,
  input logic            bd_o,
  input logic [5:0]      dbg_cause_o
);

  localparam logic [XLEN-1:0] LOW_MASK = (XLEN'(1) << BASE_LSB) - XLEN'(1);

  AST_REQ_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    (req_i && kind_i <= 5'd25) |=> redir_valid_o); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!req_i || kind_i > 5'd25) |=> !redir_valid_o); // R2
  AST_KERNEL_WITH_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    redir_valid_o |-> kernel_o); // R2
  AST_ONE_ENTRY_PATH: assert property (@(posedge clk) disable iff (rst)
    $onehot0({set_exl_o, set_erl_o, set_dm_o})); // R8
  AST_EPC_HELD_AT_EXL: assert property (@(posedge clk) disable iff (rst)
    (req_i && exl_i) |=> ($stable(epc_o) && $stable(bd_o) && !set_exl_o)); // R8
  AST_REFILL_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (req_i && !exl_i && !bev_i && refill_i && (kind_i == 5'd2 || kind_i == 5'd3))
      |=> (redir_pc_o == ($past(ebase_i) & ~LOW_MASK))); // R6
  AST_ERROR_VECTOR: assert property (@(posedge clk) disable iff (rst)
    set_erl_o |-> (set_bev_o && redir_pc_o == ERR_VEC)); // R10
  AST_DEBUG_VECTOR: assert property (@(posedge clk) disable iff (rst)
    set_dm_o |-> (redir_pc_o == DBG_VEC)); // R11
  AST_DEBUG_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((dbg_cause_o & $past(dbg_cause_o)) == $past(dbg_cause_o))); // R12

endmodule

bind trap_vector_ctl trap_vector_chk #(
  .XLEN     (XLEN),
  .BASE_LSB (BASE_LSB),
  .ERR_VEC  (ERR_VEC),
  .DBG_VEC  (DBG_VEC)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_i         (req_i),
  .kind_i        (kind_i),
  .exl_i         (exl_i),
  .bev_i         (bev_i),
  .refill_i      (refill_i),
  .ebase_i       (ebase_i),
  .redir_valid_o (redir_valid_o),
  .redir_pc_o    (redir_pc_o),
  .kernel_o      (kernel_o),
  .set_exl_o     (set_exl_o),
  .set_erl_o     (set_erl_o),
  .set_bev_o     (set_bev_o),
  .set_dm_o      (set_dm_o),
  .epc_o         (epc_o),
  .bd_o          (bd_o),
  .dbg_cause_o   (dbg_cause_o)
);

// File: tb/sim_trap_vector_ctl.sv
`timescale 1ns/1ps
module sim_trap_vector_ctl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [4:0]  kind = '0;
  logic [31:0] pc = '0;
  logic        ds = 1'b0, exl = 1'b0, bev = 1'b0, iv = 1'b0, refill = 1'b0;
  logic [1:0]  cpn = '0;
  logic [31:0] ebase = 32'h8000_1234;

  logic        rv, kern, sexl, serl, sbev, sdm, bd;
  logic [31:0] rpc, epc, erpc, dpc;
  logic [4:0]  code;
  logic [1:0]  cop;
  logic [5:0]  dbgc;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  trap_vector_ctl u0 (
    .clk(clk), .rst(rst), .req_i(req), .kind_i(kind), .pc_i(pc),
    .delay_slot_i(ds), .exl_i(exl), .bev_i(bev), .iv_i(iv), .refill_i(refill),
    .cop_num_i(cpn), .ebase_i(ebase),
    .redir_valid_o(rv), .redir_pc_o(rpc), .kernel_o(kern),
    .set_exl_o(sexl), .set_erl_o(serl), .set_bev_o(sbev), .set_dm_o(sdm),
    .epc_o(epc), .err_pc_o(erpc), .dbg_pc_o(dpc), .exc_code_o(code),
    .bd_o(bd), .cop_num_o(cop), .dbg_cause_o(dbgc)
  );

  // kind, ds, exl, bev, iv, refill, expected pc, expected code
  localparam int NV = 22;
  localparam logic [46:0] VT [NV] = '{
    {5'd0,  1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_1180, 5'd0},
    {5'd0,  1'b0,1'b0,1'b0,1'b1,1'b0, 32'h8000_1200, 5'd0},
    {5'd0,  1'b0,1'b0,1'b1,1'b1,1'b0, 32'hBFC0_0400, 5'd0},
    {5'd2,  1'b0,1'b0,1'b0,1'b0,1'b1, 32'h8000_1000, 5'd2},
    {5'd3,  1'b0,1'b1,1'b0,1'b0,1'b1, 32'h8000_1180, 5'd3},
    {5'd2,  1'b1,1'b0,1'b0,1'b0,1'b0, 32'h8000_1180, 5'd2},
    {5'd3,  1'b0,1'b0,1'b1,1'b0,1'b1, 32'hBFC0_0200, 5'd3},
    {5'd1,  1'b0,1'b0,1'b0,1'b0,1'b1, 32'h8000_1180, 5'd1},
    {5'd4,  1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_1180, 5'd4},
    {5'd5,  1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_1180, 5'd5},
    {5'd6,  1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_1180, 5'd6},
    {5'd7,  1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_1180, 5'd7},
    {5'd8,  1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_1180, 5'd8},
    {5'd9,  1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_1180, 5'd9},
    {5'd10, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_1180, 5'd10},
    {5'd12, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_1180, 5'd12},
    {5'd13, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_1180, 5'd13},
    {5'd14, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_1180, 5'd15},
    {5'd15, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_1180, 5'd23},
    {5'd16, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_1180, 5'd24},
    {5'd17, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'hA000_1100, 5'd30},
    {5'd17, 1'b0,1'b0,1'b1,1'b0,1'b0, 32'hBFC0_0300, 5'd30}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge; returns at the next falling edge with req dropped
  task automatic fire(input logic [4:0] k, input logic [31:0] p, input logic d,
                      input logic e, input logic b, input logic v, input logic r,
                      input logic [1:0] c);
    kind = k; pc = p; ds = d; exl = e; bev = b; iv = v; refill = r; cpn = c;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'd0, rv}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", {31'd0, rv}, 32'd0);
    chk("R1 pc after reset", rpc, 32'd0);
    chk("R1 epc after reset", epc, 32'd0);
    chk("R1 pulses after reset", {26'd0, kern, sexl, serl, sbev, sdm, bd}, 32'd0);
    chk("R1 dbg cause after reset", {26'd0, dbgc}, 32'd0);

    // table walk: R3 codes, R4 base, R5 interrupt offset, R6 refill, R7 cache error
    for (int i = 0; i < NV; i++) begin
      fire(VT[i][46:42], 32'h0040_0010, VT[i][41], VT[i][40], VT[i][39],
           VT[i][38], VT[i][37], 2'd0);
      chk($sformatf("R2 valid row %0d", i), {31'd0, rv}, 32'd1);
      chk($sformatf("R2 kernel row %0d", i), {31'd0, kern}, 32'd1);
      chk($sformatf("R3/R4 pc row %0d", i), rpc, VT[i][36:5]);
      chk($sformatf("R3 code row %0d", i), {27'd0, code}, {27'd0, VT[i][4:0]});
    end

    // R2: pulse lasts one cycle
    @(negedge clk);
    chk("R2 pulse ends", {31'd0, rv}, 32'd0);

    // R8: delay-slot save with EXL clear
    fire(5'd8, 32'h0000_1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    chk("R8 epc delay slot", epc, 32'h0000_0FFC);
    chk("R8 bd set", {31'd0, bd}, 32'd1);
    chk("R8 set_exl", {31'd0, sexl}, 32'd1);
    // R8 and R6 together: refill with EXL set keeps epc and falls to 0x180
    fire(5'd2, 32'h0000_2000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0);
    chk("R8 epc held", epc, 32'h0000_0FFC);
    chk("R8 bd held", {31'd0, bd}, 32'd1);
    chk("R8 no set_exl", {31'd0, sexl}, 32'd0);
    chk("R6 exl refill offset", rpc, 32'h8000_1180);
    chk("R3 code at exl", {27'd0, code}, 32'd2);
    // R8 non-delay save clears bd
    fire(5'd9, 32'h0000_2400, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    chk("R8 epc plain", epc, 32'h0000_2400);
    chk("R8 bd clear", {31'd0, bd}, 32'd0);

    // R9: coprocessor number
    fire(5'd11, 32'h0000_2800, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3);
    chk("R9 cop num", {30'd0, cop}, 32'd3);
    chk("R3 copu code", {27'd0, code}, 32'd11);
    fire(5'd8, 32'h0000_2C00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1);
    chk("R9 cop num kept", {30'd0, cop}, 32'd3);

    // R10: NMI from delay slot, soft reset plain
    fire(5'd18, 32'h0000_3000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    chk("R10 err pc", erpc, 32'h0000_2FFC);
    chk("R10 vector", rpc, 32'hBFC0_0000);
    chk("R10 set erl/bev", {30'd0, serl, sbev}, 32'd3);
    chk("R10 no set_exl", {31'd0, sexl}, 32'd0);
    chk("R10 epc kept", epc, 32'h0000_2C00);
    chk("R10 code kept", {27'd0, code}, 32'd8);
    fire(5'd19, 32'h0000_3400, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    chk("R10 soft reset err pc", erpc, 32'h0000_3400);

    // R11, R12: debug paths
    fire(5'd20, 32'h0000_5000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    chk("R11 step keeps pc", dpc, 32'h0000_5000);
    chk("R11 debug vector", rpc, 32'hBFC0_0480);
    chk("R11 set_dm", {31'd0, sdm}, 32'd1);
    chk("R12 step bit", {26'd0, dbgc}, 32'h01);
    fire(5'd23, 32'h0000_6000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    chk("R11 breakpoint delay slot", dpc, 32'h0000_5FFC);
    chk("R12 sticky bits", {26'd0, dbgc}, 32'h09);
    fire(5'd25, 32'h0000_6400, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    chk("R12 data break load bit", {26'd0, dbgc}, 32'h29);
    chk("R11 epc kept", epc, 32'h0000_2C00);

    // R2: illegal kind ignored
    fire(5'd28, 32'h0000_7000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2);
    chk("R2 illegal no valid", {31'd0, rv}, 32'd0);
    chk("R2 illegal epc kept", epc, 32'h0000_2C00);
    chk("R2 illegal err pc kept", erpc, 32'h0000_3400);
    chk("R2 illegal cop kept", {30'd0, cop}, 32'd3);

    // back-to-back requests on consecutive edges
    kind = 5'd0; pc = 32'h0000_8000; ds = 1'b0; exl = 1'b0; bev = 1'b0;
    iv = 1'b0; refill = 1'b0; req = 1'b1;
    @(negedge clk);
    chk("R2 first of pair", rpc, 32'h8000_1180);
    chk("R8 first of pair epc", epc, 32'h0000_8000);
    kind = 5'd12; pc = 32'h0000_8100;
    @(negedge clk);
    req = 1'b0;
    chk("R2 second of pair valid", {31'd0, rv}, 32'd1);
    chk("R8 second of pair epc", epc, 32'h0000_8100);
    chk("R3 second of pair code", {27'd0, code}, 32'd12);
    @(negedge clk);
    chk("R2 pair ends", {31'd0, rv}, 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule